// File: doc/BRIEF.md
# Multiplexed Video Memory Bus Sequencer

This block turns single-byte read and write requests from a video processor's internal logic into cycles on an external video-memory bus. The bus addresses 14 bits. The low address byte and the data byte share one set of bidirectional pins. The upper six address bits have pins of their own. Each external access opens with a one-cycle address-latch pulse, during which the low byte sits on the shared pins so that an outside latch can capture it. In the next cycle the shared pins carry data, and an active-low read or write strobe marks the direction.

Addresses whose upper six bits are all ones form the palette window, 0x3F00 to 0x3FFF. Requests in this window never reach the external bus. They are served from a small internal palette store indexed by the low five address bits. A requester offers a request while `req_ready` is high and takes the result on the cycle where `resp_done` is high.

Top module: `vbus_seq`

## Requirements
- R1: While reset is asserted and after it is released, `rd_n` and `wr_n` are high, `ale` is low, the shared pins are released, `resp_done` is low and `req_ready` is high.
- R2: An accepted request outside the palette window raises `ale` in the next cycle for exactly one cycle, with `ad[7:0]` equal to address bits 7:0 and `addr_hi` equal to address bits 13:8.
- R3: The cycle after the `ale` cycle is the strobe cycle, and `addr_hi` keeps its value through it.
- R4: For an external write, the strobe cycle has `wr_n` low, `rd_n` high, and the write byte driven on `ad`.
- R5: For an external read, the strobe cycle has `rd_n` low, `wr_n` high, and the shared pins released. `resp_rdata` equals the byte on `ad` in that cycle, and `resp_done` is high.
- R6: A write to 0x3F00..0x3FFF raises no `ale` and no strobe. It stores the byte at palette index address[4:0] and raises `resp_done` in the cycle after acceptance.
- R7: A read from 0x3F00..0x3FFF raises no `ale` and no strobe. In the cycle after acceptance it returns the byte last stored at index address[4:0] on `resp_rdata`, with `resp_done` high.
- R8: A request is accepted only while `req_ready` is high. `req_ready` is low for every cycle of an access, and `req_valid` held through an access starts no second access.
- R9: `rd_n` and `wr_n` are never low together, and either one is low only in the cycle right after an `ale` cycle.
- R10: An external access takes two cycles (latch, then strobe), and `resp_done` is high only in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Sequencer idle; a request is taken at the next edge |
| resp_done | output | 1 | Last cycle of an access |
| resp_rdata | output | 8 | Read byte, valid while resp_done is high after a read |
| ale | output | 1 | Address-latch strobe |
| ad | inout | 8 | Shared low-address / data pins |
| addr_hi | output | 6 | Address bits 13:8 |
| rd_n | output | 1 | Active-low external read strobe |
| wr_n | output | 1 | Active-low external write strobe |

## Verification
On every cycle the assertions check the bus protocol: the single-cycle latch pulse, the strobe following it, the exclusive strobes, who drives the shared pins in each strobe direction, the upper address held through the access, and the absence of any external activity for palette-window requests. Only the bench scenarios can show that the right bytes move: the low address on the pins during the latch pulse, write data on the pins, read data returned from the pins, and palette contents written and read back through index aliasing at the window edges 0x3EFF, 0x3F00 and 0x3FFF.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LATCH  = 2'd1,
    ST_STROBE = 2'd2,
    ST_PAL    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/vbus_pal.sv
module vbus_pal #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= store_q[idx];
  end
endmodule

// File: rtl/vbus_fsm.sv
module vbus_fsm
  import vbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOW_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic                    pal_hit,
  output logic                    ready,
  output logic                    done,
  output logic                    ext_rd_phase,
  output logic                    ale,
  output logic [LOW_W-1:0]        ad_o,
  output logic                    ad_oe,
  output logic [ADDR_W-LOW_W-1:0] addr_hi,
  output logic                    rd_n,
  output logic                    wr_n
);
  seq_state_e        state_q;
  logic              is_wr_q;
  logic [DATA_W-1:0] wbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      wbuf_q  <= '0;
      ale     <= 1'b0;
      ad_o    <= '0;
      ad_oe   <= 1'b0;
      addr_hi <= '0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (pal_hit) begin
              state_q <= ST_PAL;
            end else begin
              state_q <= ST_LATCH;
              ale     <= 1'b1;
              ad_o    <= req_addr[LOW_W-1:0];
              ad_oe   <= 1'b1;
              addr_hi <= req_addr[ADDR_W-1:LOW_W];
              is_wr_q <= req_write;
              wbuf_q  <= req_wdata;
            end
          end
        end
        ST_LATCH: begin
          state_q <= ST_STROBE;
          ale     <= 1'b0;
          rd_n    <= is_wr_q;
          wr_n    <= !is_wr_q;
          ad_oe   <= is_wr_q;
          ad_o    <= wbuf_q[LOW_W-1:0];
        end
        ST_STROBE: begin
          state_q <= ST_IDLE;
          rd_n    <= 1'b1;
          wr_n    <= 1'b1;
          ad_oe   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready        = (state_q == ST_IDLE);
  assign done         = (state_q == ST_STROBE) || (state_q == ST_PAL);
  assign ext_rd_phase = (state_q == ST_STROBE) && !is_wr_q;
endmodule

// File: rtl/vbus_seq.sv
module vbus_seq #(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOW_W    = 8,
  parameter int unsigned PAL_IDXW = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_ready,
  output logic                    resp_done,
  output logic [DATA_W-1:0]       resp_rdata,
  output logic                    ale,
  inout  wire  [LOW_W-1:0]        ad,
  output logic [ADDR_W-LOW_W-1:0] addr_hi,
  output logic                    rd_n,
  output logic                    wr_n
);
  localparam int unsigned HI_W = ADDR_W - LOW_W;

  function automatic logic in_pal_window(input logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:LOW_W];
  endfunction

  function automatic logic [PAL_IDXW-1:0] pal_index(input logic [ADDR_W-1:0] a);
    return a[PAL_IDXW-1:0];
  endfunction

  logic             pal_hit;
  logic             accept;
  logic             pal_wr;
  logic             pal_rd;
  logic             ext_rd_phase;
  logic [LOW_W-1:0] ad_o;
  logic             ad_oe;
  logic [DATA_W-1:0] pal_rdata;

  assign pal_hit = in_pal_window(req_addr);
  assign accept  = req_ready && req_valid;
  assign pal_wr  = accept && pal_hit && req_write;
  assign pal_rd  = accept && pal_hit && !req_write;

  vbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .pal_hit      (pal_hit),
    .ready        (req_ready),
    .done         (resp_done),
    .ext_rd_phase (ext_rd_phase),
    .ale          (ale),
    .ad_o         (ad_o),
    .ad_oe        (ad_oe),
    .addr_hi      (addr_hi),
    .rd_n         (rd_n),
    .wr_n         (wr_n)
  );

  vbus_pal #(.DATA_W(DATA_W), .IDX_W(PAL_IDXW)) pal_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (pal_wr),
    .rd_en (pal_rd),
    .idx   (pal_index(req_addr)),
    .wdata (req_wdata),
    .rdata (pal_rdata)
  );

  assign ad = ad_oe ? ad_o : {LOW_W{1'bz}};

  generate
    if (DATA_W == LOW_W) begin : g_rd_same
      assign resp_rdata = ext_rd_phase ? ad : pal_rdata;
    end else begin : g_rd_pad
      assign resp_rdata = ext_rd_phase ? DATA_W'(ad) : pal_rdata;
    end
  endgenerate

  wire unused_hi_w = (HI_W == 0);
endmodule

// File: rtl/vbus_seq_chk.sv
module vbus_seq_chk #(
  parameter int unsigned HI_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            resp_done,
  input logic            ale,
  input logic [HI_W-1:0] addr_hi,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic            pal_hit
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (rd_n && wr_n && !ale && !ad_oe)); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R2
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) ale |=> (!rd_n || !wr_n)); // R3
  AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n) ale |=> $stable(addr_hi)); // R3
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> ad_oe); // R4
  AST_RD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe); // R5
  AST_PAL_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n) (req_ready && req_valid && pal_hit) |=> (!ale && rd_n && wr_n && resp_done)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (ale || !rd_n || !wr_n) |-> !req_ready); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R9
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> $past(ale)); // R9
  AST_DONE_NOT_LATCH: assert property (@(posedge clk) disable iff (!rst_n) ale |-> !resp_done); // R10
endmodule

bind vbus_seq vbus_seq_chk #(.HI_W(ADDR_W - LOW_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .resp_done (resp_done),
  .ale       (ale),
  .addr_hi   (addr_hi),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .pal_hit   (pal_hit)
);

// File: tb/vbus_seq_tb.sv
`timescale 1ns/1ps
module vbus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, resp_done, ale, rd_n, wr_n;
  logic [7:0]  resp_rdata;
  logic [5:0]  addr_hi;
  wire  [7:0]  ad;
  logic [7:0]  mem_byte = '0;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] pal_model [32];
  logic [31:0] pal_known = '0;

  always #2 clk = ~clk;

  assign ad = !rd_n ? mem_byte : 8'bz;

  vbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_done(resp_done), .resp_rdata(resp_rdata), .ale(ale), .ad(ad),
    .addr_hi(addr_hi), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic bit is_pal(input logic [13:0] a);
    return a >= 14'h3F00;
  endfunction

  function automatic logic [7:0] ext_byte(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b10};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [13:0] a, input logic [7:0] d, input bit hold);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    mem_byte = ext_byte(a);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    if (is_pal(a)) begin
      chk(!ale && rd_n && wr_n, wr ? "R6 no external activity" : "R7 no external activity",
          {ale, rd_n, wr_n}, 3'b011);
      chk(resp_done == 1'b1, wr ? "R6 done" : "R7 done", resp_done, 1);
      if (wr) begin
        pal_model[a[4:0]] = d;
        pal_known[a[4:0]] = 1'b1;
      end else if (pal_known[a[4:0]]) begin
        chk(resp_rdata == pal_model[a[4:0]], "R7 palette data", resp_rdata, pal_model[a[4:0]]);
      end
      req_valid = 1'b0;
    end else begin
      chk(ale == 1'b1 && rd_n && wr_n, "R2 latch cycle", {ale, rd_n, wr_n}, 3'b111);
      chk(ad == a[7:0], "R2 low address on pins", ad, a[7:0]);
      chk(addr_hi == a[13:8], "R2 high address", addr_hi, a[13:8]);
      chk(resp_done == 1'b0 && req_ready == 1'b0, "R10 not done in latch", {resp_done, req_ready}, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(ale == 1'b0, "R3 latch one cycle", ale, 0);
      chk(addr_hi == a[13:8], "R3 high address held", addr_hi, a[13:8]);
      chk(resp_done == 1'b1 && req_ready == 1'b0, "R10 done in strobe", {resp_done, req_ready}, 2'b10);
      if (wr) begin
        chk(!wr_n && rd_n, "R4 write strobe", {rd_n, wr_n}, 2'b10);
        chk(ad == d, "R4 write data", ad, d);
      end else begin
        chk(!rd_n && wr_n, "R5 read strobe", {rd_n, wr_n}, 2'b01);
        chk(resp_rdata == ext_byte(a), "R5 read data", resp_rdata, ext_byte(a));
      end
    end
    @(negedge clk);
    chk(!ale && rd_n && wr_n && !resp_done, "R8 no second access", {ale, rd_n, wr_n, resp_done}, 4'b0110);
    chk(req_ready == 1'b1, "R8 ready after access", req_ready, 1);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && !ale && !resp_done && req_ready, "R1 in reset",
        {rd_n, wr_n, ale, resp_done, req_ready}, 5'b11001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_n && wr_n && !ale && !resp_done && req_ready, "R1 after reset",
        {rd_n, wr_n, ale, resp_done, req_ready}, 5'b11001);

    // directed corners
    access(1'b1, 14'h0000, 8'hA5, 1'b0);
    access(1'b0, 14'h3EFF, 8'h00, 1'b0);
    access(1'b1, 14'h3F00, 8'h11, 1'b0);
    access(1'b1, 14'h3FFF, 8'h22, 1'b0);
    access(1'b0, 14'h3F00, 8'h00, 1'b0);
    access(1'b0, 14'h3F1F, 8'h00, 1'b0);
    access(1'b1, 14'h3F05, 8'h5C, 1'b0);
    access(1'b0, 14'h3FE5, 8'h00, 1'b0);
    access(1'b0, 14'h1234, 8'h00, 1'b1);
    access(1'b1, 14'h2BCD, 8'h7E, 1'b1);

    for (int i = 0; i < 200; i++) begin
      logic [13:0] a;
      a = 14'($urandom);
      if ($urandom_range(0, 9) < 4) a[13:8] = 6'h3F;
      access(1'($urandom), a, 8'($urandom), ($urandom_range(0, 7) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule